// File: doc/BRIEF.md
# ALU Operand Bypass Selector

This block picks where each ALU operand of the instruction in the execute stage comes from, in a five-stage in-order integer pipeline. Each source register number of that instruction is compared with the destination register of the two older instructions still in flight. One of them sits in the memory-stage pipeline register and the other in the write-back-stage pipeline register. When a match is found on a producer that will really write a register, the result held in that stage is bypassed to the ALU input in place of the value read from the register file during decode.

The block is pure combinational logic: a compare-and-priority control part drives a small set of strobes into a datapath part, which encodes the per-operand select and applies the operand mux. The mux is included so that the routed operand can be observed directly. Stall generation and branch handling live elsewhere.

Top module: `fwd_unit`

## Requirements
- R1: With no qualifying match, an operand's select is 2'b00 and its ALU operand equals its register-file value; the value 2'b11 is never produced.
- R2: When the memory-stage producer has its write flag set, a nonzero destination, and a destination equal to the operand's source register, the select is 2'b10 and the operand equals the memory-stage ALU result.
- R3: When only the write-back-stage producer qualifies (write flag set, nonzero destination equal to the source), the select is 2'b01 and the operand equals the write-back result.
- R4: When both producers qualify for the same source, the memory-stage producer wins (select 2'b10), since it holds the newer value.
- R5: A producer whose write flag is low is never bypassed, even when its destination matches; selection then falls to the other producer or to the register file.
- R6: A destination of register 0 never triggers bypass, whatever the write flag.
- R7: Operand 0 and operand 1 are resolved independently; both may be bypassed in the same cycle, from the same or from different producers.
- R8: The selects and operands follow their inputs within the same cycle; the block holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exSrcReg | input | 2x5 | Source register numbers of the execute-stage instruction, index 0 and 1 |
| exRfData | input | 2x32 | Register-file operand values latched at decode, per operand |
| memDstReg | input | 5 | Destination register of the memory-stage instruction |
| memRegWrite | input | 1 | Memory-stage instruction will write a register |
| memAluResult | input | 32 | ALU result held in the memory-stage pipeline register |
| wbDstReg | input | 5 | Destination register of the write-back-stage instruction |
| wbRegWrite | input | 1 | Write-back-stage instruction will write a register |
| wbResult | input | 32 | Write-back value (ALU result or loaded data) |
| fwdSel | output | 2x2 | Per-operand select: 00 register file, 10 memory stage, 01 write-back stage |
| aluOperand | output | 2x32 | Per-operand value delivered to the ALU |

## Verification
Every result here is due in the very cycle its inputs change, because no register lies between any input and any output. The bench therefore applies each stimulus on a rising clock edge and samples both selects and both operands at the following falling edge, half a period later, before the next stimulus. Directed cases cover each priority corner and register 0, and a seeded random stream draws register numbers from a narrow range so that matches on both producers are frequent.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  localparam int unsigned OP_COUNT = 2;

  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_WB      = 2'b01,
    SRC_MEM     = 2'b10
  } fwdSrc_e;

  typedef struct packed {
    logic [OP_COUNT-1:0] takeMem;
    logic [OP_COUNT-1:0] takeWb;
  } fwdStrobes_t;

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] srcReg,
  input  logic [REG_W-1:0] memDst,
  input  logic             memWr,
  input  logic [REG_W-1:0] wbDst,
  input  logic             wbWr,
  output logic             hitMem,
  output logic             hitWb
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic memCand;
  logic wbCand;

  always_comb begin
    memCand = memWr && (memDst != ZERO_REG) && (memDst == srcReg);
    wbCand  = wbWr  && (wbDst  != ZERO_REG) && (wbDst  == srcReg);
    hitMem  = memCand;
    hitWb   = wbCand && !memCand;
  end

  always_comb begin
    assert_single_source_R4: assert (!(hitMem && hitWb));
    if (hitWb) begin
      assert_wb_qualifies_R3: assert (wbWr && (srcReg == wbDst));
    end
  end

endmodule

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [OP_COUNT-1:0][REG_W-1:0] srcReg,
  input  logic [REG_W-1:0]               memDst,
  input  logic                           memWr,
  input  logic [REG_W-1:0]               wbDst,
  input  logic                           wbWr,
  output fwdStrobes_t                    strobes
);

  logic [OP_COUNT-1:0] hitMemVec;
  logic [OP_COUNT-1:0] hitWbVec;

  for (genvar op = 0; op < OP_COUNT; op++) begin : g_op
    fwd_match #(.REG_W(REG_W)) u_match (
      .srcReg (srcReg[op]),
      .memDst (memDst),
      .memWr  (memWr),
      .wbDst  (wbDst),
      .wbWr   (wbWr),
      .hitMem (hitMemVec[op]),
      .hitWb  (hitWbVec[op])
    );

    always_comb begin
      if (strobes.takeMem[op]) begin
        assert_mem_needs_write_R5: assert (memWr);
        assert_mem_not_reg0_R6: assert (memDst != '0);
      end
      if (strobes.takeWb[op]) begin
        assert_wb_needs_write_R5: assert (wbWr);
        assert_wb_not_reg0_R6: assert (wbDst != '0);
      end
    end
  end

  always_comb begin
    strobes.takeMem = hitMemVec;
    strobes.takeWb  = hitWbVec;
  end

endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  fwdStrobes_t                     strobes,
  input  logic [OP_COUNT-1:0][DATA_W-1:0] rfData,
  input  logic [DATA_W-1:0]               memData,
  input  logic [DATA_W-1:0]               wbData,
  output logic [OP_COUNT-1:0][1:0]        selOut,
  output logic [OP_COUNT-1:0][DATA_W-1:0] operand
);

  for (genvar op = 0; op < OP_COUNT; op++) begin : g_mux
    fwdSrc_e selCode;

    always_comb begin
      if (strobes.takeMem[op])      selCode = SRC_MEM;
      else if (strobes.takeWb[op])  selCode = SRC_WB;
      else                          selCode = SRC_REGFILE;
    end

    always_comb begin
      selOut[op] = selCode;
      unique case (selCode)
        SRC_MEM: operand[op] = memData;
        SRC_WB:  operand[op] = wbData;
        default: operand[op] = rfData[op];
      endcase
    end

    always_comb begin
      assert_sel_legal_R1: assert (selOut[op] != 2'b11);
      if (selOut[op] == 2'b10) begin
        assert_mem_value_R2: assert (operand[op] == memData);
      end
      if (selOut[op] == 2'b01) begin
        assert_wb_value_R3: assert (operand[op] == wbData);
      end
      if (selOut[op] == 2'b00) begin
        assert_rf_value_R1: assert (operand[op] == rfData[op]);
      end
    end
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic [OP_COUNT-1:0][REG_W-1:0]  exSrcReg,
  input  logic [OP_COUNT-1:0][DATA_W-1:0] exRfData,
  input  logic [REG_W-1:0]                memDstReg,
  input  logic                            memRegWrite,
  input  logic [DATA_W-1:0]               memAluResult,
  input  logic [REG_W-1:0]                wbDstReg,
  input  logic                            wbRegWrite,
  input  logic [DATA_W-1:0]               wbResult,
  output logic [OP_COUNT-1:0][1:0]        fwdSel,
  output logic [OP_COUNT-1:0][DATA_W-1:0] aluOperand
);

  fwdStrobes_t strobes;

  fwd_ctrl #(.REG_W(REG_W)) u_ctrl (
    .srcReg  (exSrcReg),
    .memDst  (memDstReg),
    .memWr   (memRegWrite),
    .wbDst   (wbDstReg),
    .wbWr    (wbRegWrite),
    .strobes (strobes)
  );

  fwd_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobes (strobes),
    .rfData  (exRfData),
    .memData (memAluResult),
    .wbData  (wbResult),
    .selOut  (fwdSel),
    .operand (aluOperand)
  );

endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;

  localparam int unsigned REG_W  = 5;
  localparam int unsigned DATA_W = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [1:0][REG_W-1:0]  exSrcReg;
  logic [1:0][DATA_W-1:0] exRfData;
  logic [REG_W-1:0]       memDstReg;
  logic                   memRegWrite;
  logic [DATA_W-1:0]      memAluResult;
  logic [REG_W-1:0]       wbDstReg;
  logic                   wbRegWrite;
  logic [DATA_W-1:0]      wbResult;
  logic [1:0][1:0]        fwdSel;
  logic [1:0][DATA_W-1:0] aluOperand;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  fwd_unit #(.REG_W(REG_W), .DATA_W(DATA_W)) u_dut (
    .exSrcReg     (exSrcReg),
    .exRfData     (exRfData),
    .memDstReg    (memDstReg),
    .memRegWrite  (memRegWrite),
    .memAluResult (memAluResult),
    .wbDstReg     (wbDstReg),
    .wbRegWrite   (wbRegWrite),
    .wbResult     (wbResult),
    .fwdSel       (fwdSel),
    .aluOperand   (aluOperand)
  );

  function automatic logic [1:0] expSel(input logic [REG_W-1:0] src);
    if (memRegWrite && memDstReg != 0 && memDstReg == src) return 2'b10;
    if (wbRegWrite && wbDstReg != 0 && wbDstReg == src)    return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DATA_W-1:0] expVal(input int op);
    case (expSel(exSrcReg[op]))
      2'b10:   return memAluResult;
      2'b01:   return wbResult;
      default: return exRfData[op];
    endcase
  endfunction

  task automatic checkVal(input string req, input string what,
                          input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive at a rising edge, sample half a period later (R8: zero-cycle path).
  task automatic apply(input string req,
                       input logic [REG_W-1:0] s0, input logic [REG_W-1:0] s1,
                       input logic [REG_W-1:0] md, input logic mw,
                       input logic [REG_W-1:0] wd, input logic ww);
    @(posedge clk);
    exSrcReg[0]  = s0;
    exSrcReg[1]  = s1;
    memDstReg    = md;
    memRegWrite  = mw;
    wbDstReg     = wd;
    wbRegWrite   = ww;
    exRfData[0]  = $urandom;
    exRfData[1]  = $urandom;
    memAluResult = $urandom;
    wbResult     = $urandom;
    @(negedge clk);
    for (int op = 0; op < 2; op++) begin
      checkVal(req, $sformatf("sel%0d", op), {30'd0, fwdSel[op]}, {30'd0, expSel(exSrcReg[op])});
      checkVal(req, $sformatf("operand%0d", op), aluOperand[op], expVal(op));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    exSrcReg = '0; exRfData = '0; memDstReg = '0; memRegWrite = 1'b0;
    memAluResult = '0; wbDstReg = '0; wbRegWrite = 1'b0; wbResult = '0;
    @(negedge clk);
    // R1: idle inputs give register-file path
    checkVal("R1", "idle sel0", {30'd0, fwdSel[0]}, 32'd0);
    checkVal("R1", "idle sel1", {30'd0, fwdSel[1]}, 32'd0);

    apply("R1", 5'd3, 5'd4, 5'd7, 1'b1, 5'd8, 1'b1);   // R1 no match
    apply("R2", 5'd3, 5'd4, 5'd3, 1'b1, 5'd9, 1'b1);   // R2 mem on op0
    apply("R3", 5'd3, 5'd4, 5'd9, 1'b1, 5'd4, 1'b1);   // R3 wb on op1
    apply("R4", 5'd6, 5'd6, 5'd6, 1'b1, 5'd6, 1'b1);   // R4 both match
    apply("R5", 5'd6, 5'd2, 5'd6, 1'b0, 5'd6, 1'b1);   // R5 mem write low -> wb
    apply("R5", 5'd6, 5'd2, 5'd6, 1'b0, 5'd6, 1'b0);   // R5 both low -> rf
    apply("R6", 5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);   // R6 reg 0
    apply("R6", 5'd0, 5'd5, 5'd0, 1'b1, 5'd5, 1'b1);   // R6 reg 0 with wb on op1
    apply("R7", 5'd10, 5'd11, 5'd10, 1'b1, 5'd11, 1'b1); // R7 different producers
    apply("R7", 5'd12, 5'd12, 5'd12, 1'b1, 5'd1, 1'b1);  // R7 same producer both
    apply("R7", 5'd31, 5'd13, 5'd13, 1'b1, 5'd31, 1'b1); // R7 swapped

    for (int i = 0; i < 400; i++) begin
      apply("R8", 5'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4),
            1'($urandom % 2), 5'($urandom % 4), 1'($urandom % 2));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule